// File: doc/BRIEF.md
# Time-Multiplexed Multichannel CIC Decimator

This block is the first decimation stage behind a bank of single-bit delta or sigma-delta modulators. Each input frame carries one bit per channel, and all bits of a frame are sampled on the same clock. A single fourth-order cascaded integrator-comb datapath, built only from adders, subtractors and registers, serves every channel in turn. The per-channel integrator and comb state lives in small register arrays, and each channel's entries are read, updated and written back during that channel's time slot.

When a frame is accepted, the block visits the channels one per clock in ascending index order. A counter of accepted frames selects one frame in every R as the decimation frame. On that frame only, the comb section runs as well, and one multi-bit sample per channel leaves the block on consecutive cycles, tagged with its channel index and a valid strobe. The decimation factor R is taken from an input when the block is reset or flushed. It then stays fixed until the next reset or flush, which also clears the state of every channel.

Top module: `tdm_cic_decim`

## Requirements
- R1: Each input bit is mapped to +1 (bit 1) or -1 (bit 0). Once the filter has warmed up, a channel that holds 1 gives +R^4 and a channel that holds 0 gives -R^4.
- R2: On a decimation frame the block emits exactly NCH samples on consecutive cycles, with `out_chan` running 0, 1, ..., NCH-1. On any other frame `out_valid` stays low.
- R3: The decimation factor is `dec_in` clamped to the range 8..32 (below 8 gives 8, above 32 gives 32). It is sampled while `rst_n` is low or on a `flush` cycle. Samples appear after every R accepted frames, and the first one follows the R-th frame after the reset or flush.
- R4: A change of `dec_in` without a reset or flush has no effect on the output rate.
- R5: `out_data` is a 22-bit two's-complement value. It equals the +/-1 stream of its channel passed through four cascaded running sums of length R, evaluated at the decimation frame, where frames before the last reset or flush count as zero.
- R6: Channels are independent. The output of one channel depends only on that channel's bit position in `frame_bits` (bit c belongs to channel c).
- R7: A `flush` cycle clears every integrator, comb delay and the frame counter, so the output that follows matches the output after a reset.
- R8: During and after reset `out_valid` is low, and it stays low until the R-th frame has been accepted.
- R9: A frame is accepted on a rising edge where `frame_valid` is high and the block is idle. The sample for channel c is registered on the (c+1)-th edge after that one. Frames must be spaced at least NCH+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also samples `dec_in` |
| flush | input | 1 | Synchronous clear of all channel state; samples `dec_in` |
| frame_valid | input | 1 | Strobe marking a new input frame |
| frame_bits | input | NCH | One modulator bit per channel, bit c for channel c |
| dec_in | input | 6 | Requested decimation factor |
| out_valid | output | 1 | Decimated sample valid |
| out_chan | output | 2 | Channel index of the sample |
| out_data | output | 22 | Signed decimated sample |

## Verification
The assertions assume that `frame_valid` is raised only while the block is idle, which means frames are at least NCH+1 cycles apart. They also assume that `dec_in` holds a defined value whenever reset or flush is active. The stimulus strobes `frame_valid` for one cycle and then waits NCH+1 clocks before the next frame. It pulses `flush` only between frames and sets `dec_in` before every reset or flush. Under these conditions the channel tags rise in strict order, and the factor register can change only on reset or flush.

// File: rtl/cicd_pkg.sv
package cicd_pkg;

  // bit 1 -> +1, bit 0 -> -1, as a 2-bit signed step
  function automatic logic signed [1:0] bit_to_step(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction

  // limit a requested decimation factor to the supported window
  function automatic int unsigned clamp_rate(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/cicd_seq.sv
module cicd_seq #(
  parameter int NCH  = 4,
  parameter int RMIN = 8,
  parameter int RMAX = 32,
  localparam int RW = $clog2(RMAX + 1),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          frame_valid,
  input  logic [NCH-1:0] frame_bits,
  input  logic [RW-1:0] dec_in,
  output logic          slot_en,
  output logic [CW-1:0] slot_idx,
  output logic          slot_bit,
  output logic          dump
);
  import cicd_pkg::*;

  logic          busy;
  logic [CW-1:0] slot;
  logic [NCH-1:0] bits_q;
  logic [RW-1:0] frm_cnt;
  logic [RW-1:0] rate_q;
  logic          last_slot;

  assign last_slot = (slot == CW'(NCH - 1));
  assign dump      = (frm_cnt == rate_q - RW'(1));
  assign slot_en   = busy;
  assign slot_idx  = slot;
  assign slot_bit  = bits_q[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      slot    <= '0;
      bits_q  <= '0;
      frm_cnt <= '0;
      rate_q  <= RW'(clamp_rate(32'(dec_in), RMIN, RMAX));
    end else if (flush) begin
      busy    <= 1'b0;
      slot    <= '0;
      bits_q  <= '0;
      frm_cnt <= '0;
      rate_q  <= RW'(clamp_rate(32'(dec_in), RMIN, RMAX));
    end else if (frame_valid && !busy) begin
      busy   <= 1'b1;
      slot   <= '0;
      bits_q <= frame_bits;
    end else if (busy) begin
      if (last_slot) begin
        busy    <= 1'b0;
        slot    <= '0;
        frm_cnt <= dump ? '0 : frm_cnt + RW'(1);
      end else begin
        slot <= slot + CW'(1);
      end
    end
  end

  // input rule: a new frame only while idle
  assert_frame_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !busy);

  assert_rate_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q >= RW'(RMIN)) && (rate_q <= RW'(RMAX)));

  assert_rate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(rate_q));

  assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_slot && !flush) |=> (busy && slot == $past(slot) + CW'(1)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_cnt < rate_q);

endmodule

// File: rtl/cicd_integ.sv
module cicd_integ #(
  parameter int NCH   = 4,
  parameter int ORDER = 4,
  parameter int W     = 22,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                en,
  input  logic [CW-1:0]       idx,
  input  logic                bit_in,
  output logic signed [W-1:0] integ_out
);
  import cicd_pkg::*;

  logic signed [W-1:0] acc_q [ORDER][NCH];
  logic signed [W-1:0] nxt   [ORDER+1];
  logic signed [1:0]   step;

  assign step   = bit_to_step(bit_in);
  assign nxt[0] = {{(W-2){step[1]}}, step};

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    assign nxt[k+1] = acc_q[k][idx] + nxt[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < NCH; c++) acc_q[k][c] <= '0;
      end else if (flush) begin
        for (int c = 0; c < NCH; c++) acc_q[k][c] <= '0;
      end else if (en) begin
        acc_q[k][idx] <= nxt[k+1];
      end
    end
  end

  assign integ_out = nxt[ORDER];

  // first integrator moves by exactly one step per visit
  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flush) |=> ((acc_q[0][$past(idx)] - $past(acc_q[0][idx])) inside {W'(1), {W{1'b1}}}));

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (acc_q[ORDER-1][0] == '0));

endmodule

// File: rtl/cicd_comb.sv
module cicd_comb #(
  parameter int NCH   = 4,
  parameter int ORDER = 4,
  parameter int W     = 22,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                en,
  input  logic [CW-1:0]       idx,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] dly_q [ORDER][NCH];
  logic signed [W-1:0] cs    [ORDER+1];

  assign cs[0] = din;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    assign cs[k+1] = cs[k] - dly_q[k][idx];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < NCH; c++) dly_q[k][c] <= '0;
      end else if (flush) begin
        for (int c = 0; c < NCH; c++) dly_q[k][c] <= '0;
      end else if (en) begin
        dly_q[k][idx] <= cs[k];
      end
    end
  end

  assign dout = cs[ORDER];

  // comb delays only move on decimation slots
  assert_comb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush) |=> $stable(dly_q[0][0]));

endmodule

// File: rtl/tdm_cic_decim.sv
module tdm_cic_decim #(
  parameter int NCH   = 4,
  parameter int RMIN  = 8,
  parameter int RMAX  = 32,
  parameter int ORDER = 4,
  localparam int RW = $clog2(RMAX + 1),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int W  = 2 + ORDER * $clog2(RMAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                frame_valid,
  input  logic [NCH-1:0]      frame_bits,
  input  logic [RW-1:0]       dec_in,
  output logic                out_valid,
  output logic [CW-1:0]       out_chan,
  output logic signed [W-1:0] out_data
);
  localparam longint GAIN = longint'(RMAX) ** ORDER;

  logic                slot_en;
  logic [CW-1:0]       slot_idx;
  logic                slot_bit;
  logic                dump;
  logic                comb_en;
  logic signed [W-1:0] integ_val;
  logic signed [W-1:0] comb_val;

  cicd_seq #(.NCH(NCH), .RMIN(RMIN), .RMAX(RMAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .frame_valid(frame_valid), .frame_bits(frame_bits), .dec_in(dec_in),
    .slot_en(slot_en), .slot_idx(slot_idx), .slot_bit(slot_bit), .dump(dump)
  );

  cicd_integ #(.NCH(NCH), .ORDER(ORDER), .W(W)) u_integ (
    .clk(clk), .rst_n(rst_n), .flush(flush), .en(slot_en),
    .idx(slot_idx), .bit_in(slot_bit), .integ_out(integ_val)
  );

  assign comb_en = slot_en && dump;

  cicd_comb #(.NCH(NCH), .ORDER(ORDER), .W(W)) u_comb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .en(comb_en),
    .idx(slot_idx), .din(integ_val), .dout(comb_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= comb_en;
      out_chan  <= slot_idx;
      out_data  <= comb_val;
    end
  end

  assert_chan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_chan == $past(out_chan) + CW'(1)));

  assert_first_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_chan == '0));

  assert_last_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_valid) && !$past(flush)) |-> ($past(out_chan) == CW'(NCH - 1)));

  assert_out_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((longint'(out_data) <= GAIN) && (longint'(out_data) >= -GAIN)));

endmodule

// File: tb/tdm_cic_decim_tb.sv
module tdm_cic_decim_tb_top;
  localparam int NCH  = 4;
  localparam int MAXF = 160;
  localparam int NT   = 6;
  // table: requested factor, expected factor, pattern, frames, outputs per channel
  localparam int T_REQ  [NT] = '{8, 32, 13, 3, 45, 20};
  localparam int T_EFF  [NT] = '{8, 32, 13, 8, 32, 20};
  localparam int T_KIND [NT] = '{0, 1, 3, 2, 4, 3};
  localparam int T_NFR  [NT] = '{32, 128, 65, 40, 128, 60};
  localparam int T_OUTS [NT] = '{4, 4, 5, 5, 4, 3};
  localparam longint T_LAST0 [NT] = '{4096, -1048576, 0, 0, 1048576, 0};
  localparam bit T_CHKL [NT] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n, flush, frame_valid;
  logic [NCH-1:0] frame_bits;
  logic [5:0] dec_in;
  logic out_valid;
  logic [1:0] out_chan;
  logic signed [21:0] out_data;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int cur_rate, nfr, outs;
  longint last [NCH];
  longint hs [5][NCH][MAXF];

  always #2.5 clk = ~clk;

  tdm_cic_decim dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .frame_valid(frame_valid),
    .frame_bits(frame_bits), .dec_in(dec_in), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pat(input int kind, input int n, input int c);
    case (kind)
      0: return 1'b1;
      1: return 1'b0;
      2: return 1'((n + c) % 2);
      3: return ((n * 7 + c * 13 + (n >> 2)) % 5) < 2;
      default: return (c == 0);
    endcase
  endfunction

  // four cascaded running sums of length cur_rate
  task automatic model_frame(input logic [NCH-1:0] bits);
    for (int c = 0; c < NCH; c++) begin
      hs[0][c][nfr] = bits[c] ? 1 : -1;
      for (int k = 1; k < 5; k++) begin
        longint s = 0;
        for (int j = 0; j < cur_rate; j++)
          if (nfr - j >= 0) s += hs[k-1][c][nfr-j];
        hs[k][c][nfr] = s;
      end
    end
  endtask

  task automatic send_frame(input logic [NCH-1:0] bits);
    bit dmp;
    model_frame(bits);
    dmp = ((nfr % cur_rate) == cur_rate - 1);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_bits  = bits;
    @(negedge clk);
    frame_valid = 1'b0;
    chk(out_valid == 1'b0, "R9", out_valid, 0);
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      if (dmp) begin
        chk(out_valid == 1'b1, "R2", out_valid, 1);
        chk(out_chan == 2'(c), "R2", out_chan, c);
        chk(longint'(out_data) == hs[4][c][nfr], "R5", out_data, hs[4][c][nfr]);
        last[c] = out_data;
        if (c == 0) outs++;
      end else begin
        chk(out_valid == 1'b0, "R8", out_valid, 0);
      end
    end
    nfr++;
  endtask

  task automatic do_flush(input int eff);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    cur_rate = eff;
    nfr = 0;
    outs = 0;
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; frame_valid = 1'b0; frame_bits = '0;
    dec_in = 6'd8; cur_rate = 8; nfr = 0; outs = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", out_valid, 0);

    // table walk: R1 R3 R5 R6
    for (int e = 0; e < NT; e++) begin
      dec_in = 6'(T_REQ[e]);
      do_flush(T_EFF[e]);
      for (int n = 0; n < T_NFR[e]; n++) begin
        logic [NCH-1:0] b;
        for (int c = 0; c < NCH; c++) b[c] = pat(T_KIND[e], n, c);
        send_frame(b);
      end
      chk(outs == T_OUTS[e], "R3", outs, T_OUTS[e]);
      if (T_CHKL[e]) chk(last[0] == T_LAST0[e], "R1", last[0], T_LAST0[e]);
      if (T_KIND[e] == 4) chk(last[1] == -1048576, "R6", last[1], -1048576);
    end

    // R4: change dec_in with no flush
    dec_in = 6'd8;
    do_flush(8);
    dec_in = 6'd20;
    for (int n = 0; n < 16; n++) send_frame(4'b1111);
    chk(outs == 2, "R4", outs, 2);

    // R7: flush in the middle of accumulated state
    for (int n = 0; n < 3; n++) send_frame(4'b0101);
    dec_in = 6'd8;
    do_flush(8);
    for (int n = 0; n < 32; n++) send_frame(4'b1111);
    chk(outs == 4, "R7", outs, 4);
    chk(last[2] == 4096, "R7", last[2], 4096);

    // reset mid-run samples a new factor (R3, R8)
    for (int n = 0; n < 3; n++) send_frame(4'b0011);
    @(negedge clk);
    dec_in = 6'd10;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", out_valid, 0);
    rst_n = 1'b1;
    cur_rate = 10; nfr = 0; outs = 0;
    for (int n = 0; n < 20; n++) begin
      logic [NCH-1:0] b;
      for (int c = 0; c < NCH; c++) b[c] = pat(3, n, c);
      send_frame(b);
    end
    chk(outs == 2, "R3", outs, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule